// File: doc/BRIEF.md
# Threshold-Programmable DMA Data FIFO

This block is a 16-byte data buffer that sits between a disk-side byte stream and a host DMA channel during the data-transfer part of a command. It works in either direction. In the to-host direction the disk side pushes bytes and the host removes them with DMA acknowledges. In the to-disk direction the host supplies bytes with DMA acknowledges and the disk side removes them. Only DMA transfers are supported; there is no programmed-I/O data path.

A configuration strobe loads three things: an enable bit, a 4-bit threshold field and the transfer direction. The service threshold is the field value plus one, so it runs from 1 to 16 bytes. It is measured as the bytes the disk side has on hand: free space when moving to the host, stored bytes when moving to the disk. When the threshold is reached the DMA request goes up. It then stays up until the host has completely emptied the buffer (to host) or completely filled it (to disk). With the enable bit clear, which is the reset state, the buffer shrinks to a single slot and every byte takes its own DMA cycle.

Pushes into a full buffer and pops from an empty one change nothing. They set a sticky error flag.

Top module: `dma_thr_fifo`

## Requirements
- R1: After synchronous reset, dsk_level is 0, dma_req is 0 and xfer_err is 0. The configuration is disabled, with the to-host direction (cfg_to_host=1) selected.
- R2: With the FIFO enabled the capacity is 16 bytes. Bytes leave in the order they entered, and the head byte is presented on both host_rdata and dsk_rdata whenever dsk_level is non-zero.
- R3: The threshold is cfg_thr_m1 + 1. In the to-host direction, dma_req rises on the edge where occupancy becomes non-zero and free space (capacity minus dsk_level) becomes less than or equal to the threshold.
- R4: In the to-host direction, once raised, dma_req stays high until dsk_level reaches 0, and it falls on that same edge.
- R5: In the to-disk direction (cfg_to_host=0), dma_req rises on the edge where dsk_level is at or below the threshold and the FIFO is not full.
- R6: In the to-disk direction, once raised, dma_req stays high until the FIFO is full, and it falls on that same edge.
- R7: With cfg_fifo_en=0 the capacity is 1 byte and the threshold is 1. In the to-host direction dma_req is high exactly when one byte is held. In the to-disk direction dma_req is high exactly when the slot is empty, except in the cycle that follows a configuration load.
- R8: A push while full, or a pop while empty, leaves dsk_level and the stored data unchanged and sets xfer_err. xfer_err stays set until reset.
- R9: A cycle with cfg_load=1 empties the FIFO, clears dma_req, ignores that cycle's push and pop strobes, keeps xfer_err, and applies the new configuration from the next cycle.
- R10: In the to-host direction dsk_push writes dsk_wdata and dma_ack pops, and dsk_pop is ignored. In the to-disk direction dma_ack writes host_wdata and dsk_pop pops, and dsk_push is ignored.
- R11: A legal push and a legal pop in the same cycle leave dsk_level unchanged. Legality is judged on the level before the edge, so a push while full is refused even if a pop happens in the same cycle.
- R12: dsk_level and dma_req are registered and both change on the clock edge that takes the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Load configuration and flush the FIFO |
| cfg_fifo_en | input | 1 | 1: 16-byte buffering; 0: single-byte mode |
| cfg_thr_m1 | input | 4 | Threshold minus one (0..15) |
| cfg_to_host | input | 1 | 1: disk to host; 0: host to disk |
| dsk_push | input | 1 | Disk side writes dsk_wdata (to-host direction) |
| dsk_wdata | input | 8 | Byte from the disk side |
| dsk_pop | input | 1 | Disk side takes the head byte (to-disk direction) |
| dsk_rdata | output | 8 | Head byte for the disk side |
| dsk_level | output | 5 | Bytes currently stored |
| dma_req | output | 1 | DMA service request to the host |
| dma_ack | input | 1 | DMA acknowledge: one byte moved with the host |
| host_wdata | input | 8 | Byte from the host (to-disk direction) |
| host_rdata | output | 8 | Head byte for the host |
| xfer_err | output | 1 | Sticky overrun/underrun flag |

## Verification
The assertions check several rules on every cycle. The level never exceeds the capacity. A refused push or pop leaves the level alone and sets the sticky flag, and the flag never clears. A raised request only falls when the buffer is empty (to host) or full (to disk). A configuration load leaves an empty buffer with no request. Data ordering cannot be shown by the assertions, and neither can the exact edge where the request rises for a given threshold value, the single-slot behaviour in both directions, or the inactive-side strobes being ignored. The bench's directed threshold sweeps and its model-checked random traffic show those.

// File: rtl/dtf_pkg.sv
package dtf_pkg;

    localparam int DEPTH = 16;
    localparam int DW    = 8;
    localparam int THR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);

    typedef logic [LVL_W-1:0] lvl_t;
    typedef logic [DW-1:0]    byte_t;

    typedef enum logic {
        DIR_TO_DISK = 1'b0,
        DIR_TO_HOST = 1'b1
    } dir_e;

    typedef struct packed {
        logic             en;
        logic [THR_W-1:0] thr_m1;
        dir_e             dir;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{en: 1'b0, thr_m1: '0, dir: DIR_TO_HOST};

    // Usable slots: full depth when buffering, one slot otherwise.
    function automatic lvl_t cap_of(logic en);
        return en ? lvl_t'(DEPTH) : lvl_t'(1);
    endfunction

    // Programmed field plus one; forced to one in single-byte mode.
    function automatic lvl_t thr_of(cfg_t c);
        return c.en ? (lvl_t'(c.thr_m1) + lvl_t'(1)) : lvl_t'(1);
    endfunction

    // Condition that raises the request, evaluated on the next level.
    function automatic logic req_trigger(dir_e d, lvl_t lvl, lvl_t cap, lvl_t thr);
        if (d == DIR_TO_HOST)
            return (lvl != '0) && ((cap - lvl) <= thr);
        else
            return (lvl < cap) && (lvl <= thr);
    endfunction

    // Condition that ends a service burst.
    function automatic logic req_done(dir_e d, lvl_t lvl, lvl_t cap);
        return (d == DIR_TO_HOST) ? (lvl == '0) : (lvl == cap);
    endfunction

endpackage

// File: rtl/dtf_cfg.sv
module dtf_cfg
    import dtf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cfg_t cfg_in,
    output dir_e dir,
    output lvl_t cap,
    output lvl_t thr
);

    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else if (load)
            cfg_q <= cfg_in;
    end

    assign dir = cfg_q.dir;
    assign cap = cap_of(cfg_q.en);
    assign thr = thr_of(cfg_q);

endmodule

// File: rtl/dtf_store.sv
module dtf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic [LW-1:0] cap,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [LW-1:0] level,
    output logic [LW-1:0] level_nxt,
    output logic          err
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          push_ok, pop_ok;

    function automatic logic [PW-1:0] ptr_inc(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Legality is judged on the level held before the edge.
    assign push_ok = push && (level < cap);
    assign pop_ok  = pop  && (level != '0);

    always_comb begin
        if (flush)
            level_nxt = '0;
        else begin
            unique case ({push_ok, pop_ok})
                2'b10:   level_nxt = level + 1'b1;
                2'b01:   level_nxt = level - 1'b1;
                default: level_nxt = level;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
            err   <= 1'b0;
        end else begin
            level <= level_nxt;
            if (flush) begin
                wp <= '0;
                rp <= '0;
            end else begin
                if (push_ok) wp <= ptr_inc(wp);
                if (pop_ok)  rp <= ptr_inc(rp);
                if ((push && !push_ok) || (pop && !pop_ok))
                    err <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush && push_ok)
            mem[wp] <= wdata;
    end

    assign rdata = mem[rp];

    // R2: occupancy never exceeds the usable capacity
    a_r2_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= cap);

    // R8: refused push leaves the level and raises the flag
    a_r8_full_push_held: assert property (@(posedge clk) disable iff (rst)
        (!flush && push && !pop && level == cap) |=> ($stable(level) && err));

    // R8: refused pop leaves the level and raises the flag
    a_r8_empty_pop_held: assert property (@(posedge clk) disable iff (rst)
        (!flush && pop && !push && level == '0) |=> (level == '0 && err));

    // R8: flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R11: legal simultaneous push and pop keep the level
    a_r11_both_legal: assert property (@(posedge clk) disable iff (rst)
        (!flush && push && pop && level != '0 && level < cap) |=> $stable(level));

endmodule

// File: rtl/dtf_req.sv
module dtf_req
    import dtf_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  dir_e dir,
    input  lvl_t cap,
    input  lvl_t thr,
    input  lvl_t level_nxt,
    output logic req
);

    logic done_n, trig_n;

    // Evaluated on the level the store is about to take, so the request
    // and the level move on the same edge.
    assign done_n = req_done(dir, level_nxt, cap);
    assign trig_n = req_trigger(dir, level_nxt, cap, thr);

    always_ff @(posedge clk) begin
        if (rst || flush)
            req <= 1'b0;
        else
            req <= !done_n && (req || trig_n);
    end

endmodule

// File: rtl/dma_thr_fifo.sv
module dma_thr_fifo
    import dtf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic             cfg_fifo_en,
    input  logic [THR_W-1:0] cfg_thr_m1,
    input  logic             cfg_to_host,
    input  logic             dsk_push,
    input  logic [DW-1:0]    dsk_wdata,
    input  logic             dsk_pop,
    output logic [DW-1:0]    dsk_rdata,
    output logic [LVL_W-1:0] dsk_level,
    output logic             dma_req,
    input  logic             dma_ack,
    input  logic [DW-1:0]    host_wdata,
    output logic [DW-1:0]    host_rdata,
    output logic             xfer_err
);

    cfg_t  cfg_in;
    dir_e  dir;
    lvl_t  cap, thr, level_nxt;
    logic  is_host;
    logic  st_push, st_pop;
    byte_t st_wdata, st_rdata;

    assign cfg_in = '{en:     cfg_fifo_en,
                      thr_m1: cfg_thr_m1,
                      dir:    cfg_to_host ? DIR_TO_HOST : DIR_TO_DISK};

    dtf_cfg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (cfg_load),
        .cfg_in (cfg_in),
        .dir    (dir),
        .cap    (cap),
        .thr    (thr)
    );

    // Route the producer and consumer sides by the configured direction.
    assign is_host  = (dir == DIR_TO_HOST);
    assign st_push  = is_host ? dsk_push  : dma_ack;
    assign st_wdata = is_host ? dsk_wdata : host_wdata;
    assign st_pop   = is_host ? dma_ack   : dsk_pop;

    dtf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (cfg_load),
        .cap       (cap),
        .push      (st_push),
        .pop       (st_pop),
        .wdata     (st_wdata),
        .rdata     (st_rdata),
        .level     (dsk_level),
        .level_nxt (level_nxt),
        .err       (xfer_err)
    );

    dtf_req u_req (
        .clk       (clk),
        .rst       (rst),
        .flush     (cfg_load),
        .dir       (dir),
        .cap       (cap),
        .thr       (thr),
        .level_nxt (level_nxt),
        .req       (dma_req)
    );

    assign host_rdata = st_rdata;
    assign dsk_rdata  = st_rdata;

    // R9: configuration load leaves an empty buffer and no request
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (rst)
        cfg_load |=> (dsk_level == '0 && !dma_req));

    // R4: a to-host request only drops when the buffer is empty
    a_r4_read_hold: assert property (@(posedge clk) disable iff (rst)
        (dma_req && is_host && !cfg_load) |=> (dma_req || dsk_level == '0));

    // R4: no to-host request with nothing to read
    a_r4_no_req_empty: assert property (@(posedge clk) disable iff (rst)
        (is_host && dsk_level == '0) |-> !dma_req);

    // R6: a to-disk request only drops when the buffer is full
    a_r6_write_hold: assert property (@(posedge clk) disable iff (rst)
        (dma_req && !is_host && !cfg_load) |=> (dma_req || dsk_level == cap));

    // R6: no to-disk request with the buffer full
    a_r6_no_req_full: assert property (@(posedge clk) disable iff (rst)
        (!is_host && dsk_level == cap) |-> !dma_req);

    // R7: single-slot to-host mode requests exactly when the byte is held
    a_r7_single_read: assert property (@(posedge clk) disable iff (rst)
        (cap == lvl_t'(1) && is_host) |-> (dma_req == (dsk_level == lvl_t'(1))));

endmodule

// File: tb/sim_dma_thr_fifo.sv
module sim_dma_thr_fifo;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0, cfg_fifo_en = 1'b0, cfg_to_host = 1'b1;
    logic [3:0] cfg_thr_m1 = '0;
    logic       dsk_push = 1'b0, dsk_pop = 1'b0, dma_ack = 1'b0;
    logic [7:0] dsk_wdata = '0, host_wdata = '0;
    logic [7:0] dsk_rdata, host_rdata;
    logic [4:0] dsk_level;
    logic       dma_req, xfer_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model state
    byte unsigned mq[$];
    bit m_req, m_err, m_en, m_dir;
    int m_thr_m1;

    always #2.5 clk = ~clk;

    dma_thr_fifo u0 (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_fifo_en(cfg_fifo_en),
        .cfg_thr_m1(cfg_thr_m1), .cfg_to_host(cfg_to_host),
        .dsk_push(dsk_push), .dsk_wdata(dsk_wdata), .dsk_pop(dsk_pop),
        .dsk_rdata(dsk_rdata), .dsk_level(dsk_level), .dma_req(dma_req),
        .dma_ack(dma_ack), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .xfer_err(xfer_err)
    );

    function automatic int f_cap(bit en);
        return en ? 16 : 1;
    endfunction

    function automatic int f_thr(bit en, int thr_m1);
        return en ? thr_m1 + 1 : 1;
    endfunction

    function automatic bit f_raise(bit to_host, int n, int cap, int thr);
        if (to_host) return (n > 0) && (cap - n <= thr);
        return (n < cap) && (n <= thr);
    endfunction

    function automatic bit f_end(bit to_host, int n, int cap);
        return to_host ? (n == 0) : (n == cap);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mq.delete();
        m_req = 0; m_err = 0; m_en = 0; m_dir = 1; m_thr_m1 = 0;
    endtask

    task automatic model_step();
        int cap, thr, n;
        bit psh, pp, pok, pook;
        byte unsigned wd;
        if (cfg_load) begin
            mq.delete();
            m_req = 0;
            m_en = cfg_fifo_en; m_dir = cfg_to_host; m_thr_m1 = int'(cfg_thr_m1);
            return;
        end
        cap = f_cap(m_en);
        thr = f_thr(m_en, m_thr_m1);
        if (m_dir) begin psh = dsk_push; wd = dsk_wdata;  pp = dma_ack; end
        else       begin psh = dma_ack;  wd = host_wdata; pp = dsk_pop; end
        n = mq.size();
        pok  = psh && (n < cap);
        pook = pp && (n > 0);
        if ((psh && !pok) || (pp && !pook)) m_err = 1;
        if (pook) void'(mq.pop_front());
        if (pok) mq.push_back(wd);
        n = mq.size();
        if (f_end(m_dir, n, cap)) m_req = 0;
        else if (f_raise(m_dir, n, cap, thr)) m_req = 1;
    endtask

    task automatic compare(string tag);
        chk(tag, "dsk_level", int'(dsk_level), mq.size());
        chk(tag, "dma_req", int'(dma_req), int'(m_req));
        chk(tag, "xfer_err", int'(xfer_err), int'(m_err));
        if (mq.size() > 0) begin
            chk(tag, "host_rdata", int'(host_rdata), int'(mq[0]));
            chk(tag, "dsk_rdata", int'(dsk_rdata), int'(mq[0]));
        end
    endtask

    // Inputs are set after a falling edge; one rising edge is taken and
    // outputs are compared 1 ns later (R12: same-edge update).
    task automatic tick(string tag);
        @(posedge clk);
        model_step();
        #1;
        compare(tag);
        @(negedge clk);
        cfg_load = 0; dsk_push = 0; dsk_pop = 0; dma_ack = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        cfg_load = 0; dsk_push = 0; dsk_pop = 0; dma_ack = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    task automatic load_cfg(bit en, int thr_m1, bit to_host, string tag);
        cfg_load = 1; cfg_fifo_en = en; cfg_thr_m1 = 4'(thr_m1); cfg_to_host = to_host;
        tick(tag);
    endtask

    task automatic dpush(byte unsigned b, string tag);
        dsk_push = 1; dsk_wdata = b; tick(tag);
    endtask

    task automatic hack(byte unsigned b, string tag);
        dma_ack = 1; host_wdata = b; tick(tag);
    endtask

    task automatic dpop(string tag);
        dsk_pop = 1; tick(tag);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        #1;
        // R1: reset state
        chk("R1", "dsk_level", int'(dsk_level), 0);
        chk("R1", "dma_req", int'(dma_req), 0);
        chk("R1", "xfer_err", int'(xfer_err), 0);
        @(negedge clk);

        // R7: disabled after reset, to-host, single slot
        dpush(8'h11, "R7");
        chk("R7", "req with one byte", int'(dma_req), 1);
        dpush(8'h22, "R7");   // overrun into single slot (R8)
        chk("R8", "err on single-slot overrun", int'(xfer_err), 1);
        hack(8'h00, "R7");
        chk("R7", "req after drain", int'(dma_req), 0);

        // R3 / R4 / R2: enabled, threshold field 3 -> 4, to host
        do_reset();
        load_cfg(1, 3, 1, "R9");
        for (int i = 0; i < 11; i++) dpush(byte'(8'h40 + i), "R3");
        chk("R3", "no req at level 11", int'(dma_req), 0);
        dpush(8'h4B, "R3");
        chk("R3", "req at level 12", int'(dma_req), 1);
        // R11: simultaneous legal push and pop
        dsk_push = 1; dsk_wdata = 8'hC0; dma_ack = 1; tick("R11");
        chk("R11", "level unchanged", int'(dsk_level), 12);
        // R10: dsk_pop ignored in to-host direction
        dpop("R10");
        chk("R10", "dsk_pop ignored", int'(dsk_level), 12);
        // R4: drain to empty, request held until level 0
        while (mq.size() > 0) hack(8'h00, "R4");
        chk("R4", "req falls at empty", int'(dma_req), 0);
        chk("R8", "no err on exact drain", int'(xfer_err), 0);

        // R2 / R8: fill all 16, then overrun
        for (int i = 0; i < 16; i++) dpush(byte'(8'h80 + i), "R2");
        chk("R2", "full level", int'(dsk_level), 16);
        dpush(8'hEE, "R8");
        chk("R8", "level after overrun", int'(dsk_level), 16);
        chk("R8", "err set", int'(xfer_err), 1);
        // R11: push while full with a pop is still refused
        dsk_push = 1; dsk_wdata = 8'hDD; dma_ack = 1; tick("R11");
        chk("R11", "full push refused", int'(dsk_level), 15);
        // R9: load with strobes in the same cycle
        dsk_push = 1; dma_ack = 1; load_cfg(1, 7, 0, "R9");
        chk("R9", "flushed", int'(dsk_level), 0);
        chk("R9", "err kept", int'(xfer_err), 1);

        // R5 / R6: to disk, threshold 8
        do_reset();
        load_cfg(1, 7, 0, "R9");
        tick("R5");
        chk("R5", "req when empty", int'(dma_req), 1);
        for (int i = 0; i < 16; i++) hack(byte'(8'h20 + i), "R6");
        chk("R6", "req falls at full", int'(dma_req), 0);
        // R10: dsk_push ignored in to-disk direction
        dpush(8'h99, "R10");
        chk("R10", "dsk_push ignored", int'(dsk_level), 16);
        for (int i = 0; i < 7; i++) dpop("R5");
        chk("R5", "no req at level 9", int'(dma_req), 0);
        dpop("R5");
        chk("R5", "req at level 8", int'(dma_req), 1);
        while (mq.size() > 0) dpop("R2");
        dpop("R8");
        chk("R8", "underrun err", int'(xfer_err), 1);

        // R7: disabled, to disk
        do_reset();
        load_cfg(0, 9, 0, "R7");
        tick("R7");
        chk("R7", "req with empty slot", int'(dma_req), 1);
        hack(8'h5A, "R7");
        chk("R7", "req off when slot full", int'(dma_req), 0);
        dpop("R7");
        chk("R7", "req back after pop", int'(dma_req), 1);

        // Random traffic against the model (R2, R3, R5)
        do_reset();
        for (int c = 0; c < 4000; c++) begin
            if ($urandom % 120 == 0) begin
                cfg_load = 1;
                cfg_fifo_en = ($urandom % 5) != 0;
                cfg_thr_m1 = 4'($urandom);
                cfg_to_host = 1'($urandom);
            end
            dsk_push = ($urandom % 3) == 0;
            dsk_wdata = 8'($urandom);
            dsk_pop = ($urandom % 3) == 0;
            dma_ack = dma_req ? (($urandom % 4) != 0) : (($urandom % 20) == 0);
            host_wdata = 8'($urandom);
            tick("R2 random");
        end

        finish_run();
    end

endmodule